// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Access

This block gathers a parameterised set of interrupt lines (one to thirty-two) and turns them into a single request line for a processor. Each line is fixed at build time as either edge or level sensitive. A latched status register records which sources have fired. An enable mask selects which of them may reach the processor. The request goes out only while a global output switch is on.

Software works with the block through a plain 32-bit register port. A three-bit word index picks the register, and there is a write strobe, write data and a combinational read-data return. The enable mask can be loaded whole. It can also be changed one bit at a time through dedicated set and clear words, so that no read-modify-write is needed. Sources are acknowledged by writing ones. A vector word reports the pending source with the lowest number, which is the highest priority.

A second control bit decides whether hardware events are latched at all. While it is off, software may write status bits directly to test the interrupt path.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, pending, enable and control all read zero, the vector word reads 0xFFFFFFFF and `irq_out` is low.
- R2: Word index 2 loads the enable mask. A write to index 4 sets the enable bits written as one, and a write to index 5 clears them. All other enable bits keep their value. Indices 3, 4 and 5 read as zero.
- R3: A write to index 3 clears every status bit written as one and leaves the other status bits unchanged.
- R4: An input whose bit in `EDGE_MASK` is 1 sets its status bit at the first clock edge at which the input is seen high after being low. An input that stays high does not set the bit again after it is acknowledged.
- R5: An input whose bit in `EDGE_MASK` is 0 sets its status bit at every clock edge at which it is high. If it is acknowledged while still high, its status bit stays set.
- R6: Hardware events are latched only while control bit 1 (index 7) is set. Status writes at index 0 replace the status only while that bit is clear, and they are ignored while it is set.
- R7: Index 1 reads the bitwise AND of status and enable.
- R8: Index 6 reads the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R9: `irq_out` is high exactly when pending is nonzero and control bit 0 (index 7) is set.
- R10: Status and enable bits at positions at or above `NUM_SRC` read as zero and ignore writes. The control word holds only bits 1:0.
- R11: With the inputs low, the start-up sequence leaves no status, no pending source and `irq_out` low. The sequence is: enable written 0, acknowledge written all ones, then control written 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Interrupt source lines |
| bus_addr | input | 3 | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Some properties are checked by assertions on every clock. Setting and clearing single enable bits must hit only the bits written. An acknowledge with capture off must clear the bits written. Status must never gain a bit while capture is off and no status write is made. An edge event must last one cycle, and the vector must name a pending source with no lower pending one. Other behaviour can only be shown by the bench's scenarios. These are the level/edge difference after an acknowledge with the line still high, the exhaustive priority sweep over all status patterns under several enable masks, the masking of unused upper bits, and the start-up sequence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENABLE = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VECTOR = 3'd6,
    RG_CTRL   = 3'd7
  } reg_sel_e;

  localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

  // Index of the lowest set bit, 32 when none is set.
  function automatic logic [5:0] first_one(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd32;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = 6'(k);
    end
    return r;
  endfunction

  // New enable mask from the current mask and one register write.
  function automatic logic [31:0] next_enable(input logic [31:0] cur,
                                              input reg_sel_e sel,
                                              input logic [31:0] d);
    logic [31:0] r;
    r = cur;
    case (sel)
      RG_ENABLE: r = d;
      RG_SETEN:  r = cur | d;
      RG_CLREN:  r = cur & ~d;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] evt
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[i];
      end
      assign evt[i] = irq_in[i] & ~prev_q;

      // R4: an edge event never lasts two cycles
      p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> !evt[i]);
    end else begin : g_level
      assign evt[i] = irq_in[i];
    end
  end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_SRC = 32,
  localparam int IDXW   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  output logic [IDXW-1:0]    idx,
  output logic               vld
);
  import irqc_pkg::*;

  logic [31:0] wide;
  logic [5:0]  first;
  logic [NUM_SRC-1:0] below;

  always_comb begin
    wide = '0;
    wide[NUM_SRC-1:0] = pend;
  end

  assign first = first_one(wide);
  assign idx   = IDXW'(first);
  assign vld   = |pend;
  assign below = (NUM_SRC'(1) << idx) - NUM_SRC'(1);

  // R8: the reported source is pending and none below it is
  p_vec_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> pend[idx]);
  p_vec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((pend & below) == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [2:0]         bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  import irqc_pkg::*;

  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] sts_q, sts_d, en_q, en_d, evt, pend, wmask;
  logic               out_en_q, cap_en_q;
  logic [IDXW-1:0]    vec_idx;
  logic               vec_vld;
  logic               wr_sts, wr_ack, wr_sen, wr_cen, wr_ctl;
  logic [31:0]        en_wide, en_next;

  assign sel    = reg_sel_e'(bus_addr);
  assign wmask  = bus_wdata[NUM_SRC-1:0];
  assign wr_sts = bus_we && (sel == RG_STATUS);
  assign wr_ack = bus_we && (sel == RG_ACK);
  assign wr_sen = bus_we && (sel == RG_SETEN);
  assign wr_cen = bus_we && (sel == RG_CLREN);
  assign wr_ctl = bus_we && (sel == RG_CTRL);

  irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .evt(evt)
  );

  // Status: acknowledge first, then new hardware events win (level re-set).
  always_comb begin
    sts_d = sts_q;
    if (wr_ack) sts_d = sts_d & ~wmask;
    if (cap_en_q)    sts_d = sts_d | evt;
    else if (wr_sts) sts_d = wmask;
  end

  always_comb begin
    en_wide = '0;
    en_wide[NUM_SRC-1:0] = en_q;
    en_next = bus_we ? next_enable(en_wide, sel, {{(32-NUM_SRC){1'b0}}, wmask} | 32'h0)
                     : en_wide;
    en_d = en_next[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      en_q     <= '0;
      out_en_q <= 1'b0;
      cap_en_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
      if (wr_ctl) begin
        out_en_q <= bus_wdata[0];
        cap_en_q <= bus_wdata[1];
      end
    end
  end

  assign pend = sts_q & en_q;

  irqc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend), .idx(vec_idx), .vld(vec_vld)
  );

  assign irq_out = out_en_q && vec_vld;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      RG_STATUS: bus_rdata[NUM_SRC-1:0] = sts_q;
      RG_PEND:   bus_rdata[NUM_SRC-1:0] = pend;
      RG_ENABLE: bus_rdata[NUM_SRC-1:0] = en_q;
      RG_VECTOR: bus_rdata = vec_vld ? 32'(vec_idx) : NO_VECTOR;
      RG_CTRL:   bus_rdata[1:0] = {cap_en_q, out_en_q};
      default:   bus_rdata = '0;
    endcase
  end

  // R2: single-bit enable updates hit exactly the bits written
  p_set_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sen |=> ((en_q & $past(wmask)) == $past(wmask)));
  p_clr_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cen |=> ((en_q & $past(wmask)) == '0));
  p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sen |=> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask))));
  // R3: acknowledge clears the written bits while capture is off
  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !cap_en_q) |=> ((sts_q & $past(wmask)) == '0));
  // R6: with capture off and no status write, no status bit appears
  p_no_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en_q && !wr_sts) |=> ((sts_q & ~$past(sts_q)) == '0));
  // R9: request drops the cycle after the output switch is turned off
  p_out_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !bus_wdata[0]) |=> !irq_out);

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam logic [31:0] EDGES = 32'h0000_002A;
  localparam logic [31:0] ALL = (32'h1 << N) - 32'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(N), .EDGE_MASK(EDGES)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [31:0] low_idx(input logic [31:0] p);
    logic [31:0] r;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 32; k++) begin
      if (p[k] && r == 32'hFFFF_FFFF) r = k;
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ens [4];
    ens[0] = ALL; ens[1] = 32'h15; ens[2] = 32'h2A; ens[3] = 32'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1", v, (a == 6) ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);

    // R10 upper bits ignored, control holds two bits (capture off)
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R10 status", v, ALL);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R10 enable", v, ALL);
    wr(3'd7, 32'hFFFF_FFFC); rd(3'd7, v); chk("R10 ctrl", v, 32'h0);
    for (int a = 3; a < 6; a++) begin
      rd(3'(a), v); chk("R2 write-only reads zero", v, 32'h0);
    end

    // R3 acknowledge clears only written bits
    wr(3'd3, 32'h0000_0005); rd(3'd0, v); chk("R3", v, ALL & ~32'h5);

    // R11 start-up sequence
    wr(3'd2, 32'h0); wr(3'd3, 32'hFFFF_FFFF); wr(3'd7, 32'h3);
    rd(3'd0, v); chk("R11 status", v, 32'h0);
    rd(3'd1, v); chk("R11 pending", v, 32'h0);
    chk("R11 irq_out", {31'h0, irq_out}, 32'h0);

    // R2 enable set/clear sweep
    for (int i = 0; i < N; i++) begin
      wr(3'd4, 32'h1 << i); rd(3'd2, v);
      chk("R2 set", v, (32'h2 << i) - 32'h1);
    end
    for (int i = 0; i < N; i++) begin
      wr(3'd5, 32'h1 << i); rd(3'd2, v);
      chk("R2 clear", v, ALL & ~((32'h2 << i) - 32'h1));
    end

    // R6 status writes ignored with capture on
    wr(3'd0, 32'h3F); rd(3'd0, v); chk("R6 sw write ignored", v, 32'h0);

    // R4/R5 per-input edge vs level
    for (int i = 0; i < N; i++) begin
      wr(3'd3, ALL);
      @(negedge clk); irq_in[i] = 1'b1;
      @(negedge clk); rd(3'd0, v);
      chk(EDGES[i] ? "R4 capture" : "R5 capture", v, 32'h1 << i);
      repeat (2) @(negedge clk);
      wr(3'd3, 32'h1 << i); rd(3'd0, v);
      chk(EDGES[i] ? "R4 no re-set" : "R5 re-set", v, EDGES[i] ? 32'h0 : (32'h1 << i));
      irq_in[i] = 1'b0;
      wr(3'd3, ALL); rd(3'd0, v); chk("R3 final ack", v, 32'h0);
    end

    // R6 no hardware capture with capture bit clear
    wr(3'd7, 32'h1);
    @(negedge clk); irq_in = 6'h3F;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R6 no capture", v, 32'h0);
    irq_in = '0;
    @(negedge clk);

    // R7/R8/R9 exhaustive status patterns under several masks
    for (int e = 0; e < 4; e++) begin
      wr(3'd2, ens[e]);
      for (int p = 0; p < 64; p++) begin
        wr(3'd0, 32'(p));
        rd(3'd1, v); chk("R7 pending", v, 32'(p) & ens[e]);
        rd(3'd6, v); chk("R8 vector", v, low_idx(32'(p) & ens[e]));
        chk("R9 irq_out", {31'h0, irq_out}, {31'h0, ((32'(p) & ens[e]) != 0)});
      end
    end

    // R9 output switch off masks the request
    wr(3'd2, ALL); wr(3'd0, 32'h4);
    chk("R9 on", {31'h0, irq_out}, 32'h1);
    wr(3'd7, 32'h0);
    chk("R9 off", {31'h0, irq_out}, 32'h0);
    rd(3'd6, v); chk("R8 vector while off", v, 32'h2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule